// File: doc/BRIEF.md
# SPI Serial Byte-Memory Slave

This block is the target side of a serial byte-wide memory reached over SPI. The host opens a frame by pulling chip select low and sends an 8-bit command. Address, dummy and data bytes follow as the command requires. Bits travel most significant first. SI is taken on rising SCK edges and SO changes on falling SCK edges, so both clock polarities in common use (idle low, sample first edge; idle high, sample second edge) work without configuration.

The block runs on a fast system clock and oversamples every pin. Byte traffic goes to an external synchronous byte memory through a simple address, write-strobe and read-data port; read data is due one clock after the address. A status byte holds a write-enable latch, two block-protect bits and a lock bit. The lock bit, together with the write-protect pin, freezes the status byte. A hold pin pauses a frame without ending it. Commands cover latch set and clear, status read and write, plain and fast array read, array write, a fixed identification sequence and a sleep request.

Top module: `spimem_slave`

## Requirements
- R1: SI is sampled on rising SCK, SO changes on falling SCK, MSB first, and frames work with SCK idling low or idling high.
- R2: Command codes are 0x06 latch set, 0x04 latch clear, 0x05 status read, 0x01 status write, 0x03 array read, 0x0B fast array read, 0x02 array write, 0x9F identification read, 0xB9 sleep.
- R3: The status byte reads as bit7 lock, bits 6..4 zero, bit3/bit2 protect, bit1 write-enable latch, bit0 always zero; a status read repeats it for as long as the frame lasts. Latch set and latch clear change bit1.
- R4: An array write takes three address bytes, of which only the low ADDR_W bits count, then stores each data byte at consecutive addresses; it stores nothing unless the latch was set when the command began.
- R5: An array read takes three address bytes, then drives the byte at that address and the following ones for as long as the frame lasts.
- R6: A fast array read inserts one ignored byte after the address, with SO off, before data is driven.
- R7: Read and write addresses wrap from the last location to 0.
- R8: A status write with the latch set copies bit7 and bits 3..2 of its data byte and ignores the other bits. It changes nothing while the lock bit is 1 and the write-protect pin is low. The write-protect pin has no effect on array writes.
- R9: The latch clears when chip select rises after an array write that stored at least one byte, or after a status write that received its data byte with the latch set. A write frame that ends before its first full data byte leaves the latch set.
- R10: A command byte outside the table makes the rest of the frame ignored, with SO off.
- R11: While hold is low during a frame, SO is off and SCK and SI are ignored. The frame resumes where it stopped when hold returns high.
- R12: While chip select is high, SO is off and any partial byte or command is discarded.
- R13: Identification read drives the ID_BYTES bytes of ID_VALUE, most significant first, repeating for as long as the frame lasts.
- R14: The sleep command sets the asleep output. The next chip-select fall clears it, and that whole frame is ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, at least 8 times the SCK rate |
| rstN | input | 1 | Active-low synchronous reset |
| csN | input | 1 | Chip select, active low |
| sck | input | 1 | Serial clock |
| si | input | 1 | Serial data in |
| so | output | 1 | Serial data out |
| soEn | output | 1 | Output enable for so (0 = high impedance) |
| wpN | input | 1 | Write-protect pin, active low |
| holdN | input | 1 | Hold pin, active low |
| memAddr | output | ADDR_W | Byte memory address |
| memWe | output | 1 | Byte memory write strobe |
| memWrData | output | 8 | Byte memory write data |
| memRdData | input | 8 | Byte memory read data, valid one clock after memAddr |
| asleep | output | 1 | Sleep flag |

## Verification
Every pin passes two synchronizer flops and one edge register. A memory write strobe therefore comes three clocks after the eighth rising SCK edge of a data byte. A new SO bit appears about four clocks after a falling SCK edge, and the enable follows a command or address byte within three clocks. The bench holds each SCK half period for eight system clocks. It samples SO and its enable at the end of the low half, well after the fall has settled and before the next rise. The reference model queues every write it expects, and on each clock any write strobe is matched against the head of that queue. A stray or missing write is therefore caught in the cycle it happens.

// File: rtl/spimem_pkg.sv
package spimem_pkg;

  localparam logic [7:0] OP_WR_ENABLE  = 8'h06;
  localparam logic [7:0] OP_WR_DISABLE = 8'h04;
  localparam logic [7:0] OP_STAT_RD    = 8'h05;
  localparam logic [7:0] OP_STAT_WR    = 8'h01;
  localparam logic [7:0] OP_ARR_RD     = 8'h03;
  localparam logic [7:0] OP_ARR_RD_FST = 8'h0B;
  localparam logic [7:0] OP_ARR_WR     = 8'h02;
  localparam logic [7:0] OP_ID_RD      = 8'h9F;
  localparam logic [7:0] OP_SLEEP      = 8'hB9;

  typedef enum logic [1:0] {SRC_MEM, SRC_STAT, SRC_ID} src_e;

  // control -> datapath
  typedef struct packed {
    logic shiftAddr;
    logic incAddr;
    logic memWrite;
    logic drive;
    src_e src;
  } strobe_t;

  // datapath -> control
  typedef struct packed {
    logic       desel;
    logic       selFall;
    logic       selRise;
    logic       byteDone;
    logic [7:0] rxByte;
    logic       wpLow;
  } event_t;

endpackage

// File: rtl/spimem_datapath.sv
module spimem_datapath
  import spimem_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int ID_BYTES = 3,
  parameter logic [8*ID_BYTES-1:0] ID_VALUE = '0,
  parameter int ID_IW    = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  input  logic              wpN,
  input  logic              holdN,
  input  strobe_t           stb,
  input  logic [ID_IW-1:0]  idIdx,
  input  logic [7:0]        statusByte,
  input  logic [7:0]        memRdData,
  output event_t            ev,
  output logic [ADDR_W-1:0] memAddr,
  output logic [7:0]        memWrData,
  output logic              memWe,
  output logic              so,
  output logic              soEn
);

  logic [1:0] csSy, sckSy, siSy, holdSy, wpSy;
  logic       csQ, sckQ;
  logic [2:0] bitCnt;
  logic [6:0] inShift;
  logic [ADDR_W-1:0] addrReg;
  logic       soReg;
  logic [7:0] srcByte, idSel, rxByte;
  logic       csS, sckS, siS, holdS, active, sckRise, sckFall;

  always_ff @(posedge clk) begin
    if (!rstN) begin
      csSy <= 2'b11; sckSy <= 2'b00; siSy <= 2'b00;
      holdSy <= 2'b11; wpSy <= 2'b11;
      csQ <= 1'b1; sckQ <= 1'b0;
    end else begin
      csSy   <= {csSy[0], csN};
      sckSy  <= {sckSy[0], sck};
      siSy   <= {siSy[0], si};
      holdSy <= {holdSy[0], holdN};
      wpSy   <= {wpSy[0], wpN};
      csQ    <= csSy[1];
      sckQ   <= sckSy[1];
    end
  end

  assign csS     = csSy[1];
  assign sckS    = sckSy[1];
  assign siS     = siSy[1];
  assign holdS   = holdSy[1];
  assign active  = !csS && holdS;
  assign sckRise = active && sckS && !sckQ;
  assign sckFall = active && !sckS && sckQ;
  assign rxByte  = {inShift, siS};

  always_ff @(posedge clk) begin
    if (!rstN || csS) begin
      bitCnt  <= '0;
      inShift <= '0;
    end else if (sckRise) begin
      bitCnt  <= bitCnt + 3'd1;
      inShift <= {inShift[5:0], siS};
    end
  end

  always_comb begin
    ev          = '0;
    ev.desel    = csS;
    ev.selFall  = csQ && !csS;
    ev.selRise  = !csQ && csS;
    ev.byteDone = sckRise && (bitCnt == 3'd7);
    ev.rxByte   = rxByte;
    ev.wpLow    = !wpSy[1];
  end

  // address register: shift in address bytes, then count
  generate
    if (ADDR_W > 8) begin : g_wideAddr
      always_ff @(posedge clk) begin
        if (!rstN)              addrReg <= '0;
        else if (stb.shiftAddr) addrReg <= {addrReg[ADDR_W-9:0], rxByte};
        else if (stb.incAddr)   addrReg <= addrReg + 1'b1;
      end
    end else begin : g_narrowAddr
      always_ff @(posedge clk) begin
        if (!rstN)              addrReg <= '0;
        else if (stb.shiftAddr) addrReg <= rxByte[ADDR_W-1:0];
        else if (stb.incAddr)   addrReg <= addrReg + 1'b1;
      end
    end
  endgenerate

  assign memAddr   = addrReg;
  assign memWrData = rxByte;
  assign memWe     = stb.memWrite;

  assign idSel = ID_VALUE[8*(ID_BYTES-1-int'(idIdx)) +: 8];

  always_comb begin
    case (stb.src)
      SRC_STAT: srcByte = statusByte;
      SRC_ID:   srcByte = idSel;
      default:  srcByte = memRdData;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN || csS)             soReg <= 1'b0;
    else if (sckFall && stb.drive) soReg <= srcByte[~bitCnt];
  end

  assign so   = soReg;
  assign soEn = !csS && holdS && stb.drive;

  AST_HOLD_FREEZE: assert property (@(posedge clk) disable iff (!rstN)
    (!holdS && !csS) |=> $stable(bitCnt)); // R11
  AST_DESEL_CLEAR: assert property (@(posedge clk) disable iff (!rstN)
    csS |=> (bitCnt == 3'd0)); // R12
  AST_ADDR_WRAP: assert property (@(posedge clk) disable iff (!rstN)
    (stb.incAddr && !stb.shiftAddr && (addrReg == '1)) |=> (addrReg == '0)); // R7

endmodule

// File: rtl/spimem_ctrl.sv
module spimem_ctrl
  import spimem_pkg::*;
#(
  parameter int ID_BYTES = 3,
  parameter int ID_IW    = 2
) (
  input  logic             clk,
  input  logic             rstN,
  input  event_t           ev,
  output strobe_t          stb,
  output logic [ID_IW-1:0] idIdx,
  output logic [7:0]       statusByte,
  output logic             asleep
);

  typedef enum logic [3:0] {
    PH_OPC, PH_ADDR, PH_GAP, PH_RD, PH_WR, PH_SRD, PH_SWR, PH_ID, PH_SKIP
  } phase_e;

  phase_e     phase;
  logic [1:0] addrCnt;
  logic       fastRd, isWr, wrOk, clrPend;
  logic       wrLatch, statLock;
  logic [1:0] protBits;

  assign statusByte = {statLock, 3'b000, protBits, wrLatch, 1'b0};

  always_comb begin
    stb     = '0;
    stb.src = SRC_MEM;
    case (phase)
      PH_ADDR: stb.shiftAddr = ev.byteDone;
      PH_RD: begin
        stb.drive   = 1'b1;
        stb.incAddr = ev.byteDone;
      end
      PH_WR: begin
        stb.memWrite = ev.byteDone && wrOk;
        stb.incAddr  = ev.byteDone && wrOk;
      end
      PH_SRD: begin
        stb.drive = 1'b1;
        stb.src   = SRC_STAT;
      end
      PH_ID: begin
        stb.drive = 1'b1;
        stb.src   = SRC_ID;
      end
      default: ;
    endcase
  end

  always_ff @(posedge clk) begin
    if (!rstN) begin
      phase <= PH_OPC; addrCnt <= '0; fastRd <= 1'b0; isWr <= 1'b0;
      wrOk <= 1'b0; clrPend <= 1'b0; wrLatch <= 1'b0; statLock <= 1'b0;
      protBits <= '0; asleep <= 1'b0; idIdx <= '0;
    end else if (ev.desel) begin
      phase   <= PH_OPC;
      addrCnt <= '0;
      if (ev.selRise && clrPend) wrLatch <= 1'b0;
      clrPend <= 1'b0;
    end else if (ev.selFall && asleep) begin
      asleep <= 1'b0;
      phase  <= PH_SKIP;
    end else if (ev.byteDone) begin
      case (phase)
        PH_OPC: begin
          fastRd <= 1'b0;
          isWr   <= 1'b0;
          idIdx  <= '0;
          wrOk   <= wrLatch;
          case (ev.rxByte)
            OP_WR_ENABLE:  begin wrLatch <= 1'b1; phase <= PH_SKIP; end
            OP_WR_DISABLE: begin wrLatch <= 1'b0; phase <= PH_SKIP; end
            OP_STAT_RD:    phase <= PH_SRD;
            OP_STAT_WR:    phase <= PH_SWR;
            OP_ARR_RD:     phase <= PH_ADDR;
            OP_ARR_RD_FST: begin fastRd <= 1'b1; phase <= PH_ADDR; end
            OP_ARR_WR:     begin isWr <= 1'b1; phase <= PH_ADDR; end
            OP_ID_RD:      phase <= PH_ID;
            OP_SLEEP:      begin asleep <= 1'b1; phase <= PH_SKIP; end
            default:       phase <= PH_SKIP;
          endcase
        end
        PH_ADDR: begin
          addrCnt <= addrCnt + 2'd1;
          if (addrCnt == 2'd2)
            phase <= isWr ? PH_WR : (fastRd ? PH_GAP : PH_RD);
        end
        PH_GAP: phase <= PH_RD;
        PH_WR:  if (wrOk) clrPend <= 1'b1;
        PH_SWR: begin
          if (wrOk) begin
            clrPend <= 1'b1;
            if (!(statLock && ev.wpLow)) begin
              statLock <= ev.rxByte[7];
              protBits <= ev.rxByte[3:2];
            end
          end
          phase <= PH_SKIP;
        end
        PH_ID: idIdx <= (idIdx == ID_IW'(ID_BYTES-1)) ? '0 : idIdx + 1'b1;
        default: ;
      endcase
    end
  end

  AST_WRITE_NEEDS_LATCH: assert property (@(posedge clk) disable iff (!rstN)
    stb.memWrite |-> wrLatch); // R4
  AST_LOCKED_STATUS: assert property (@(posedge clk) disable iff (!rstN)
    (statLock && ev.wpLow && !ev.desel) |=> ($stable(statLock) && $stable(protBits))); // R8
  AST_LATCH_DROP: assert property (@(posedge clk) disable iff (!rstN)
    (ev.selRise && clrPend) |=> !wrLatch); // R9
  AST_SLEEP_INERT: assert property (@(posedge clk) disable iff (!rstN)
    (asleep && !ev.selFall) |=> (asleep && $stable(wrLatch) && $stable(protBits))); // R14

endmodule

// File: rtl/spimem_slave.sv
module spimem_slave
  import spimem_pkg::*;
#(
  parameter int ADDR_W   = 10,
  parameter int ID_BYTES = 3,
  parameter logic [8*ID_BYTES-1:0] ID_VALUE = 24'h7EC219
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csN,
  input  logic              sck,
  input  logic              si,
  output logic              so,
  output logic              soEn,
  input  logic              wpN,
  input  logic              holdN,
  output logic [ADDR_W-1:0] memAddr,
  output logic              memWe,
  output logic [7:0]        memWrData,
  input  logic [7:0]        memRdData,
  output logic              asleep
);

  localparam int ID_IW = (ID_BYTES > 1) ? $clog2(ID_BYTES) : 1;

  strobe_t          stb;
  event_t           ev;
  logic [ID_IW-1:0] idIdx;
  logic [7:0]       statusByte;

  spimem_ctrl #(.ID_BYTES(ID_BYTES), .ID_IW(ID_IW)) u_ctrl (
    .clk(clk), .rstN(rstN), .ev(ev), .stb(stb), .idIdx(idIdx),
    .statusByte(statusByte), .asleep(asleep)
  );

  spimem_datapath #(.ADDR_W(ADDR_W), .ID_BYTES(ID_BYTES), .ID_VALUE(ID_VALUE),
                    .ID_IW(ID_IW)) u_dp (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .wpN(wpN),
    .holdN(holdN), .stb(stb), .idIdx(idIdx), .statusByte(statusByte),
    .memRdData(memRdData), .ev(ev), .memAddr(memAddr), .memWrData(memWrData),
    .memWe(memWe), .so(so), .soEn(soEn)
  );

endmodule

// File: tb/spimem_slave_test.sv
module spimem_slave_test;

  localparam int AW   = 8;
  localparam int NID  = 3;
  localparam logic [23:0] IDV = 24'hC35A0F;
  localparam int HALF = 8;

  logic clk = 1'b0;
  always #2 clk = ~clk;

  logic rstN = 1'b0, csN = 1'b1, sck = 1'b0, si = 1'b0, wpN = 1'b1, holdN = 1'b1;
  logic so, soEn, memWe, asleep;
  logic [AW-1:0] memAddr;
  logic [7:0] memWrData, memRdData;

  spimem_slave #(.ADDR_W(AW), .ID_BYTES(NID), .ID_VALUE(IDV)) uut (
    .clk(clk), .rstN(rstN), .csN(csN), .sck(sck), .si(si), .so(so), .soEn(soEn),
    .wpN(wpN), .holdN(holdN), .memAddr(memAddr), .memWe(memWe),
    .memWrData(memWrData), .memRdData(memRdData), .asleep(asleep)
  );

  logic [7:0] mem [0:255];
  always @(posedge clk) begin
    memRdData <= mem[memAddr];
    if (memWe) mem[memAddr] <= memWrData;
  end

  // reference model
  logic [7:0] refMem [0:255];
  bit mWel, mLock, mSleep, mode3;
  bit [1:0] mProt;
  logic [7:0] expA[$], expD[$];
  int nRun = 0, nFail = 0;

  task automatic chk(input bit ok, input string req, input string what,
                     input int act, input int exp);
    nRun++;
    if (!ok) begin
      nFail++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic waitc(input int n);
    repeat (n) @(negedge clk);
  endtask

  function automatic logic [7:0] expStat();
    return {mLock, 3'b000, mProt, mWel, 1'b0};
  endfunction

  // per-clock write monitor against the model's queue (R4)
  always @(negedge clk) begin
    if (rstN && memWe) begin
      if (expA.size() == 0) chk(1'b0, "R4", "unexpected write", int'(memAddr), 0);
      else begin
        logic [7:0] a, d;
        a = expA.pop_front();
        d = expD.pop_front();
        chk(memAddr == a && memWrData == d, "R4", "write addr/data",
            int'({memAddr, memWrData}), int'({a, d}));
      end
    end
  end

  task automatic xbyte(input logic [7:0] tx, input int nbits, input int holdAt,
                       output logic [7:0] rx, output int enCnt);
    rx = '0; enCnt = 0;
    for (int i = 7; i >= 8 - nbits; i--) begin
      sck = 1'b0; si = tx[i]; waitc(HALF);
      rx[i] = so; if (soEn) enCnt++;
      sck = 1'b1; waitc(HALF);
      if (holdAt == i) begin
        holdN = 1'b0; waitc(HALF);
        chk(soEn == 1'b0, "R11", "so enable during hold", int'(soEn), 0);
        for (int k = 0; k < 3; k++) begin
          sck = 1'b0; si = ~si; waitc(HALF);
          sck = 1'b1; waitc(HALF);
        end
        holdN = 1'b1; waitc(HALF);
      end
    end
  endtask

  task automatic fBegin();
    csN = 1'b0; waitc(HALF);
  endtask

  task automatic fEnd();
    if (!mode3) begin sck = 1'b0; waitc(HALF); end
    csN = 1'b1; waitc(2*HALF);
    chk(soEn == 1'b0, "R12", "so enable while deselected", int'(soEn), 0);
  endtask

  task automatic sendAddr(input logic [23:0] a);
    logic [7:0] rx; int en;
    for (int b = 2; b >= 0; b--) begin
      xbyte(a[8*b +: 8], 8, -1, rx, en);
      chk(en == 0, "R2", "so enable in address", en, 0);
    end
  endtask

  task automatic opOnly(input logic [7:0] op, input int extra, input logic [7:0] fill,
                        input string req);
    logic [7:0] rx; int en;
    fBegin();
    xbyte(op, 8, -1, rx, en);
    chk(en == 0, req, "so enable in command byte", en, 0);
    for (int k = 0; k < extra; k++) begin
      xbyte(fill, 8, -1, rx, en);
      chk(en == 0, req, "so enable after command", en, 0);
    end
    fEnd();
    if (mSleep) mSleep = 1'b0;
    else if (op == 8'h06) mWel = 1'b1;
    else if (op == 8'h04) mWel = 1'b0;
    else if (op == 8'hB9) mSleep = 1'b1;
  endtask

  task automatic readStat(input int n, input string req);
    logic [7:0] rx; int en;
    fBegin();
    xbyte(8'h05, 8, -1, rx, en);
    for (int k = 0; k < n; k++) begin
      xbyte(8'h00, 8, -1, rx, en);
      chk(rx == expStat(), req, "status byte", int'(rx), int'(expStat()));
      chk(en == 8, "R1", "so enable on status", en, 8);
    end
    fEnd();
  endtask

  task automatic writeStat(input logic [7:0] val);
    logic [7:0] rx; int en;
    fBegin();
    xbyte(8'h01, 8, -1, rx, en);
    xbyte(val, 8, -1, rx, en);
    fEnd();
    if (mWel) begin
      if (!(mLock && !wpN)) begin mLock = val[7]; mProt = val[3:2]; end
      mWel = 1'b0;
    end
  endtask

  task automatic writeMem(input logic [23:0] a, input int n, input logic [7:0] seed,
                          input int holdByte);
    logic [7:0] rx, d, wa; int en;
    fBegin();
    xbyte(8'h02, 8, -1, rx, en);
    sendAddr(a);
    for (int k = 0; k < n; k++) begin
      d  = seed + 8'(k * 29);
      wa = a[7:0] + 8'(k);
      if (mWel) begin expA.push_back(wa); expD.push_back(d); refMem[wa] = d; end
      xbyte(d, 8, (k == holdByte) ? 3 : -1, rx, en);
    end
    fEnd();
    chk(expA.size() == 0, "R4", "writes still pending", expA.size(), 0);
    if (mWel && n > 0) mWel = 1'b0;
  endtask

  task automatic readMem(input logic [23:0] a, input int n, input bit fast,
                         input int holdByte, input string req);
    logic [7:0] rx, e; int en;
    fBegin();
    xbyte(fast ? 8'h0B : 8'h03, 8, -1, rx, en);
    sendAddr(a);
    if (fast) begin
      xbyte(8'h00, 8, -1, rx, en);
      chk(en == 0, "R6", "so enable in dummy byte", en, 0);
    end
    for (int k = 0; k < n; k++) begin
      e = refMem[a[7:0] + 8'(k)];
      xbyte(8'h00, 8, (k == holdByte) ? 4 : -1, rx, en);
      chk(rx == e, req, "read data", int'(rx), int'(e));
      chk(en == 8, req, "so enable on data", en, 8);
    end
    fEnd();
  endtask

  task automatic readId(input int n);
    logic [7:0] rx, e; int en;
    fBegin();
    xbyte(8'h9F, 8, -1, rx, en);
    for (int k = 0; k < n; k++) begin
      e = IDV[8*(NID-1-(k % NID)) +: 8];
      xbyte(8'h00, 8, -1, rx, en);
      chk(rx == e, "R13", "id byte", int'(rx), int'(e));
    end
    fEnd();
  endtask

  initial begin
    repeat (190000) @(negedge clk);
    chk(1'b0, "WDOG", "watchdog expired", 0, 1);
    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

  initial begin
    logic [7:0] rx; int en;
    for (int i = 0; i < 256; i++) begin mem[i] = 8'(i) ^ 8'h5A; refMem[i] = 8'(i) ^ 8'h5A; end
    waitc(5); rstN = 1'b1; waitc(5);
    chk(soEn == 1'b0, "R12", "reset so enable", int'(soEn), 0);
    chk(asleep == 1'b0, "R14", "reset asleep", int'(asleep), 0);
    readStat(1, "R3");

    opOnly(8'h06, 0, 8'h00, "R2"); readStat(2, "R3");
    opOnly(8'h04, 0, 8'h00, "R2"); readStat(1, "R3");

    writeMem(24'h000010, 2, 8'h33, -1);            // R4 no latch: nothing stored
    readMem(24'h000010, 2, 1'b0, -1, "R4");

    opOnly(8'h06, 0, 8'h00, "R2");
    writeMem(24'h000020, 5, 8'h11, -1);
    readStat(1, "R9");
    readMem(24'h000020, 5, 1'b0, -1, "R5");
    readMem(24'h000021, 4, 1'b1, -1, "R6");

    opOnly(8'h06, 0, 8'h00, "R2");
    writeMem(24'h1234FE, 4, 8'hA0, -1);             // wraps FE,FF,00,01
    readMem(24'hABCDFF, 3, 1'b0, -1, "R7");

    readId(5);

    writeStat(8'h8C); readStat(1, "R8");            // no latch: unchanged
    opOnly(8'h06, 0, 8'h00, "R2");
    writeStat(8'hFF); readStat(1, "R8");            // only b7,b3,b2 copied
    wpN = 1'b0;
    opOnly(8'h06, 0, 8'h00, "R2");
    writeStat(8'h00); readStat(1, "R8");            // locked, latch still drops
    opOnly(8'h06, 0, 8'h00, "R2");
    writeMem(24'h000040, 2, 8'h77, -1);             // pin ignored for array
    readMem(24'h000040, 2, 1'b0, -1, "R8");
    wpN = 1'b1;
    opOnly(8'h06, 0, 8'h00, "R2");
    writeStat(8'h00); readStat(1, "R8");

    opOnly(8'h06, 0, 8'h00, "R2");
    opOnly(8'h5A, 2, 8'h04, "R10");                 // invalid code, trailing bytes ignored
    readStat(1, "R10");

    fBegin();                                        // R12: abort mid data byte
    xbyte(8'h02, 8, -1, rx, en);
    sendAddr(24'h000050);
    xbyte(8'hAA, 4, -1, rx, en);
    fEnd();
    readStat(1, "R12");
    writeMem(24'h000050, 0, 8'h00, -1);              // address only: latch kept
    readStat(1, "R9");
    readMem(24'h000050, 1, 1'b0, -1, "R12");

    readMem(24'h000020, 3, 1'b0, 1, "R11");
    writeMem(24'h000060, 3, 8'h5C, 1);               // latch still set here
    readMem(24'h000060, 3, 1'b0, -1, "R11");

    opOnly(8'hB9, 1, 8'h06, "R14");
    chk(asleep == 1'b1, "R14", "asleep after sleep", int'(asleep), 1);
    opOnly(8'h06, 0, 8'h00, "R14");                  // wake frame ignored
    chk(asleep == 1'b0, "R14", "asleep after wake", int'(asleep), 0);
    readStat(1, "R14");

    mode3 = 1'b1; sck = 1'b1; waitc(2*HALF);
    opOnly(8'h06, 0, 8'h00, "R1");
    writeMem(24'h000080, 3, 8'h21, -1);
    readMem(24'h000080, 3, 1'b0, -1, "R1");
    readStat(1, "R1");
    readId(2);

    $display("  [TB] %0d tests run, %0d failed", nRun, nFail);
    $finish;
  end

endmodule